// File: doc/BRIEF.md
# LCD Scanline Timing and Status Interrupt Generator

This block paces the raster of a tile-based handheld display controller. A dot counter advances once per enabled dot-clock tick and a line counter steps each time a line's worth of dots has passed, wrapping after the last line of the frame. From the two counters the block derives the current display phase (object scan, pixel drawing, horizontal blank, vertical blank) and compares the line counter against a programmable compare value.

Two interrupt requests are produced. The vertical-blank request is a one-cycle pulse at the first blank line. The status request is edge-triggered: it pulses when the OR of the software-selected conditions turns from false to true. The selectable conditions are horizontal blank, vertical blank, object scan and line-compare match. An optional write glitch, selected by a parameter, makes every condition count as selected during the cycle in which the status register is written. The drawing phase is lengthened by the low three bits of the horizontal scroll value, and the horizontal blank is shortened by the same amount.

Top module: `lcd_line_timer`

## Requirements
- R1: While `lcd_on` is high, the dot counter advances only in cycles with `dot_en` high. After `DOTS_PER_LINE` advances it returns to 0 and `ly` increments. `ly` wraps from `FRAME_LINES-1` to 0. With the defaults this gives 456 dots per line, 154 lines and 70224 dots per frame.
- R2: On a visible line (`ly` < `VISIBLE_LINES`), `mode` is 2 (object scan) for dots 0 to `SCAN_DOTS-1`. It is then 3 (drawing) for `DRAW_DOTS` plus the penalty, and 0 (horizontal blank) for the rest of the line.
- R3: On lines `VISIBLE_LINES` to `FRAME_LINES-1`, `mode` is 1 (vertical blank) for the whole line, and modes 0, 2 and 3 never appear there.
- R4: The drawing penalty is `scx[2:0]`. It is captured on the step into dot 0 of each line and continuously while `lcd_on` is low, and it holds for the rest of that line.
- R5: `lyc_match` is high exactly when `ly` equals the stored compare value.
- R6: `stat_rdata` is laid out as bit 7 = 1, bit 6 = compare-match enable, bit 5 = scan enable, bit 4 = vertical-blank enable, bit 3 = horizontal-blank enable, bit 2 = `lyc_match`, bits 1:0 = `mode`. A write with `reg_sel`=0 loads bits 6:3 of `reg_wdata` into the enables. A write with `reg_sel`=1 loads the compare value. Both take effect in the next cycle.
- R7: `irq_stat` is high for one cycle, in the same cycle in which the OR of the enabled conditions becomes true after being false in the previous cycle. A condition that stays true across a change between two enabled phases gives no new pulse. All conditions are false while `lcd_on` is low.
- R8: With `WRITE_GLITCH`=1, in a cycle with a status write (`reg_we`=1, `reg_sel`=0), all four enables act as set, and `stat_rdata[6:3]` reads 4'hF. With `WRITE_GLITCH`=0, the write has no effect until the next cycle.
- R9: While `lcd_on` is low, `mode` reads 0. On the next clock edge the dot counter and `ly` are cleared, and they stay at 0 until `lcd_on` returns. Timing then restarts at line 0, dot 0.
- R10: `irq_vblank` is high for exactly one cycle, the first cycle in which `ly` equals `VISIBLE_LINES` with `lcd_on` high.
- R11: After reset, `ly` is 0, the enables and the compare value are 0, no request is pending, and `stat_rdata` reads 8'h86 with `lcd_on` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dot_en | input | 1 | Dot clock enable |
| lcd_on | input | 1 | Display enable; low stops and clears timing |
| scx | input | 8 | Horizontal scroll; low three bits stretch drawing |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status enables, 1 = line compare |
| reg_wdata | input | 8 | Register write data |
| ly | output | 8 | Current line |
| mode | output | 2 | Current display phase |
| lyc_match | output | 1 | Line equals compare value |
| stat_rdata | output | 8 | Status byte |
| irq_vblank | output | 1 | Vertical-blank request pulse |
| irq_stat | output | 1 | Status request pulse |

## Verification
The bench builds two copies side by side with a small geometry. Each has 40-dot lines, 5 visible lines plus 3 blank lines, an 8-dot scan and a 12-dot drawing base, so a frame is only 320 dots. With frames this short, every phase boundary, the penalty region, the frame wrap and the vertical-blank pulse recur hundreds of times in a short run. One copy has `WRITE_GLITCH`=1 and the other has 0, under identical stimulus. Comparing the two isolates the write glitch. The pair also shows that adjacent enabled phases do not retrigger the status request.

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
  parameter int DOTS_PER_LINE = 456,
  parameter int VISIBLE_LINES = 144,
  parameter int FRAME_LINES   = 154,
  parameter int SCAN_DOTS     = 80,
  parameter int DRAW_DOTS     = 172,
  parameter bit WRITE_GLITCH  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dot_en,
  input  logic       lcd_on,
  input  logic [7:0] scx,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ly,
  output logic [1:0] mode,
  output logic       lyc_match,
  output logic [7:0] stat_rdata,
  output logic       irq_vblank,
  output logic       irq_stat
);
  localparam int DW       = $clog2(DOTS_PER_LINE);
  localparam int DRAW_END = SCAN_DOTS + DRAW_DOTS;
  localparam logic [1:0] M_HBL  = 2'd0;
  localparam logic [1:0] M_VBL  = 2'd1;
  localparam logic [1:0] M_SCAN = 2'd2;
  localparam logic [1:0] M_DRAW = 2'd3;

  logic [DW-1:0] dot;
  logic [2:0]    pen;
  logic [3:0]    src_en;
  logic [7:0]    lyc;
  logic          line_q;
  logic          vbl_q;
  logic          line_end;
  logic          in_vbl;
  logic          stat_wr;
  logic [DW:0]   draw_stop;
  logic [3:0]    src_eff;
  logic          stat_line;

  assign line_end  = (dot == DW'(DOTS_PER_LINE - 1));
  assign in_vbl    = lcd_on && (ly >= 8'(VISIBLE_LINES));
  assign draw_stop = (DW+1)'(DRAW_END) + (DW+1)'(pen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot <= '0;
      ly  <= '0;
      pen <= '0;
    end else if (!lcd_on) begin
      dot <= '0;
      ly  <= '0;
      pen <= scx[2:0];
    end else if (dot_en) begin
      if (line_end) begin
        dot <= '0;
        pen <= scx[2:0];
        ly  <= (ly == 8'(FRAME_LINES - 1)) ? 8'd0 : ly + 8'd1;
      end else begin
        dot <= dot + DW'(1);
      end
    end
  end

  always_comb begin
    if (!lcd_on)                              mode = M_HBL;
    else if (in_vbl)                          mode = M_VBL;
    else if ({1'b0, dot} < (DW+1)'(SCAN_DOTS)) mode = M_SCAN;
    else if ({1'b0, dot} < draw_stop)         mode = M_DRAW;
    else                                      mode = M_HBL;
  end

  assign lyc_match = (ly == lyc);
  assign stat_wr   = reg_we && !reg_sel;
  assign src_eff   = (WRITE_GLITCH && stat_wr) ? 4'hF : src_en;

  assign stat_line = lcd_on && ((src_eff[0] && mode == M_HBL)  ||
                                (src_eff[1] && mode == M_VBL)  ||
                                (src_eff[2] && mode == M_SCAN) ||
                                (src_eff[3] && lyc_match));

  assign stat_rdata = {1'b1, src_eff, lyc_match, mode};
  assign irq_stat   = stat_line && !line_q;
  assign irq_vblank = in_vbl && !vbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en <= '0;
      lyc    <= '0;
      line_q <= 1'b0;
      vbl_q  <= 1'b0;
    end else begin
      if (stat_wr)           src_en <= reg_wdata[6:3];
      if (reg_we && reg_sel) lyc    <= reg_wdata;
      line_q <= stat_line;
      vbl_q  <= in_vbl;
    end
  end
endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk #(
  parameter int DOTS_PER_LINE = 456,
  parameter int VISIBLE_LINES = 144,
  parameter int FRAME_LINES   = 154,
  parameter int SCAN_DOTS     = 80,
  parameter int DW            = $clog2(DOTS_PER_LINE)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lcd_on,
  input logic          dot_en,
  input logic [DW-1:0] dot,
  input logic [7:0]    ly,
  input logic [1:0]    mode,
  input logic          irq_stat,
  input logic          irq_vblank
);
  p_dot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dot < DW'(DOTS_PER_LINE));

  p_ly_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ly < 8'(FRAME_LINES));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && !dot_en) |=> ($stable(dot) && $stable(ly)));

  p_scan_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && ly < 8'(VISIBLE_LINES) && dot < DW'(SCAN_DOTS)) |-> (mode == 2'd2));

  p_vblank_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && ly >= 8'(VISIBLE_LINES)) |-> (mode == 2'd1));

  p_stat_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat |=> !irq_stat);

  p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |=> (dot == '0 && ly == 8'd0));

  p_vbl_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vblank |-> (ly == 8'(VISIBLE_LINES) && mode == 2'd1));

  p_vbl_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vblank |=> !irq_vblank);
endmodule

bind lcd_line_timer lcd_line_timer_chk #(
  .DOTS_PER_LINE(DOTS_PER_LINE),
  .VISIBLE_LINES(VISIBLE_LINES),
  .FRAME_LINES(FRAME_LINES),
  .SCAN_DOTS(SCAN_DOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .dot_en(dot_en), .dot(dot),
  .ly(ly), .mode(mode), .irq_stat(irq_stat), .irq_vblank(irq_vblank)
);

// File: tb/test_lcd_line_timer.sv
`timescale 1ns/100ps
module test_lcd_line_timer;
  localparam int D = 40, V = 5, T = 8, S = 8, DR = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dot_en = 1'b0, lcd_on = 1'b1, reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0] scx = 8'd0, reg_wdata = 8'd0;

  logic [7:0] o_ly   [2];
  logic [1:0] o_mode [2];
  logic       o_match[2];
  logic [7:0] o_stat [2];
  logic       o_vbl  [2];
  logic       o_irq  [2];

  int total = 0, bad = 0;
  bit finished = 0;

  int m_dot = 0, m_ly = 0, m_pen = 0, m_lyc = 0;
  logic [3:0] m_en = 4'h0;
  bit m_lq[2] = '{0, 0};
  bit m_vq = 0;

  always #2.5 clk = ~clk;

  lcd_line_timer #(.DOTS_PER_LINE(D), .VISIBLE_LINES(V), .FRAME_LINES(T),
                   .SCAN_DOTS(S), .DRAW_DOTS(DR), .WRITE_GLITCH(1'b1)) i_lcd_line_timer (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .lcd_on(lcd_on), .scx(scx),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ly(o_ly[0]), .mode(o_mode[0]), .lyc_match(o_match[0]), .stat_rdata(o_stat[0]),
    .irq_vblank(o_vbl[0]), .irq_stat(o_irq[0]));

  lcd_line_timer #(.DOTS_PER_LINE(D), .VISIBLE_LINES(V), .FRAME_LINES(T),
                   .SCAN_DOTS(S), .DRAW_DOTS(DR), .WRITE_GLITCH(1'b0)) i_lcd_line_timer_nq (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .lcd_on(lcd_on), .scx(scx),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ly(o_ly[1]), .mode(o_mode[1]), .lyc_match(o_match[1]), .stat_rdata(o_stat[1]),
    .irq_vblank(o_vbl[1]), .irq_stat(o_irq[1]));

  task automatic chk(input string tag, input int inst, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s inst=%0d act=%0d exp=%0d at %0t", tag, inst, act, exp, $time);
    end
  endtask

  function automatic int exp_mode();
    if (!lcd_on) return 0;
    if (m_ly >= V) return 1;
    if (m_dot < S) return 2;
    if (m_dot < S + DR + m_pen) return 3;
    return 0;
  endfunction

  function automatic logic [3:0] eff_en(input int inst);
    return (inst == 0 && reg_we && !reg_sel) ? 4'hF : m_en;
  endfunction

  function automatic bit cond(input int inst, input int md, input bit mt);
    logic [3:0] e;
    e = eff_en(inst);
    return lcd_on && ((e[0] && md == 0) || (e[1] && md == 1) ||
                      (e[2] && md == 2) || (e[3] && mt));
  endfunction

  task automatic cycle(input bit on, input bit de, input logic [7:0] sx,
                       input bit we, input bit sel, input logic [7:0] wd);
    int md;
    bit mt;
    bit c[2];
    string mtag;
    @(negedge clk);
    lcd_on = on; dot_en = de; scx = sx; reg_we = we; reg_sel = sel; reg_wdata = wd;
    #1;
    md = exp_mode();
    mt = (m_ly == m_lyc);
    if (!on) mtag = "R9";
    else if (m_ly >= V) mtag = "R3";
    else if (m_dot >= S + DR && m_dot < S + DR + m_pen) mtag = "R4";
    else mtag = "R2";
    for (int i = 0; i < 2; i++) begin
      c[i] = cond(i, md, mt);
      chk("R1", i, o_ly[i], m_ly);
      chk(mtag, i, o_mode[i], md);
      chk("R5", i, o_match[i], mt);
      chk((we && !sel) ? "R8" : "R6", i, o_stat[i],
          {24'd0, 1'b1, eff_en(i), mt, 2'(md)});
      chk((we && !sel) ? "R8" : "R7", i, o_irq[i], c[i] && !m_lq[i]);
      chk("R10", i, o_vbl[i], (on && m_ly >= V) && !m_vq);
    end
    for (int i = 0; i < 2; i++) m_lq[i] = c[i];
    m_vq = on && m_ly >= V;
    if (we && !sel) m_en = wd[6:3];
    if (we && sel) m_lyc = wd;
    if (!on) begin
      m_dot = 0; m_ly = 0; m_pen = sx[2:0];
    end else if (de) begin
      if (m_dot == D - 1) begin
        m_dot = 0; m_pen = sx[2:0];
        m_ly = (m_ly == T - 1) ? 0 : m_ly + 1;
      end else m_dot++;
    end
  endtask

  initial begin
    #(190000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      for (int i = 0; i < 2; i++) begin
        chk("R11", i, o_ly[i], 0);
        chk("R11", i, o_stat[i], 8'h86);
        chk("R11", i, o_irq[i], 0);
        chk("R11", i, o_vbl[i], 0);
      end
    end
    @(negedge clk); rst_n = 1'b1;
    // R2 R4 R7: scan and hblank both enabled, penalty 5
    cycle(1, 1, 8'd5, 1, 0, 8'h28);
    for (int k = 0; k < 2 * D * T + 10; k++) cycle(1, 1, 8'd5, 0, 0, 0);
    // R5 R7: compare source alone on line 3
    cycle(1, 1, 8'd3, 1, 1, 8'd3);
    cycle(1, 1, 8'd3, 1, 0, 8'h40);
    for (int k = 0; k < D * T + 10; k++) cycle(1, 1, 8'd7, 0, 0, 0);
    // R8: repeated status writes with no enables
    for (int k = 0; k < 200; k++) cycle(1, 1, 8'd0, (k % 7) == 0, 0, 8'h00);
    // R9: display off then on
    for (int k = 0; k < 20; k++) cycle(0, 1, 8'd2, 0, 0, 0);
    cycle(1, 1, 8'd2, 1, 0, 8'h10);
    for (int k = 0; k < D * T + 10; k++) cycle(1, 1, 8'd2, 0, 0, 0);
    // random mix
    for (int k = 0; k < 40000; k++) begin
      bit on, de, we, sel;
      logic [7:0] sx, wd;
      on  = ($urandom % 200) != 0;
      de  = ($urandom % 4) != 0;
      we  = ($urandom % 30) == 0;
      sel = $urandom % 2;
      wd  = sel ? 8'($urandom % T) : 8'($urandom);
      sx  = (($urandom % 50) == 0) ? 8'($urandom) : scx;
      cycle(on, de, sx, we, sel, wd);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule